// File: doc/BRIEF.md
# Two-Way Virtually Indexed, Physically Tagged Cache Tag Controller

This block holds the tag side of a small two-way set-associative data cache. A lookup arrives as the low virtual address bits plus the physical page number that a translation unit produced for the same access. The set is selected with virtual address bits. The stored tag is taken from the physical address formed by joining the page number to the page offset. Each way keeps only a valid bit and a tag. Each set keeps one least-recently-used bit.

A request is accepted on a valid/ready handshake. A hit returns a response one cycle after acceptance, reporting the way that matched. A miss raises a one-cycle fill request carrying the physical address and holds the controller busy. It installs the tag in an empty way, or else in the least recently used way, and returns a miss response 16 cycles after acceptance. The set index includes one bit above the page offset. The physical address bit at that position is therefore neither part of the index nor part of the tag.

Top module: `vipt_tag_ctrl`

## Requirements
- R1: A synchronous, active-high `rst` clears every valid bit and every LRU bit. In the cycle after reset is released, `req_ready` is 1 and `resp_valid` and `fill_req` are 0, and every access then misses until its line is installed.
- R2: The set is `req_vaddr[4:3]`. The physical address is `{req_ppn, req_vaddr[3:0]}`. The tag is physical address bits [PA_W-1:5], so page number bit 0 (physical bit 4) is not compared. `fill_paddr` carries this full physical address.
- R3: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. An accepted request that matches a valid way gives `resp_valid`=1, `resp_hit`=1 and `resp_way` equal to the matching way (0 or 1) in the cycle after the accepting edge, and `req_ready` stays 1.
- R4: An accepted request that misses drops `req_ready` from the next cycle until its response. `resp_valid`=1 with `resp_hit`=0 appears 16 cycles after acceptance: it is visible after the 15th edge that follows the accepting edge, and `req_ready` is 1 again in that cycle.
- R5: A miss raises `fill_req` for exactly one cycle, the cycle after the accepting edge, with `fill_paddr` holding the physical address of the access.
- R6: On a miss, an invalid way is chosen before a valid one, with way 0 before way 1. `resp_way` on a miss response reports the way that was installed.
- R7: When both ways of the set are valid, the miss replaces the least recently used way. The set's LRU bit is updated on every hit and every install so that it names the way not just used. At most one way matches any lookup.
- R8: `req_valid` raised while `req_ready` is 0 has no effect: no response, no fill and no change to tags or LRU state result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | VA_W (5) | Low virtual address bits: page offset and set index |
| req_ppn | input | PA_W-PG_W (8) | Translated physical page number |
| req_ready | output | 1 | Controller idle and able to accept a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response was a hit (1) or a miss (0) |
| resp_way | output | 1 | Way that hit or was installed |
| fill_req | output | 1 | One-cycle line fill request |
| fill_paddr | output | PA_W (12) | Physical address of the access being filled |

## Verification
The bench builds the block with its default parameters: a 12-bit physical address, 8-byte lines, 4 sets, 16-byte pages and a 16-cycle miss. With these values the index bit 4 sits above the page offset. Two page numbers that differ only in their lowest bit therefore share a line, and the bench exercises that case directly. With only four sets of two ways, a few accesses to one set fill both ways and force evictions that follow the LRU order. A behavioural model, compared every cycle, also follows a burst of back-to-back requests and a busy-time request that must be dropped.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

   // controller phase: idle and accepting, or waiting out a line fill
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } ctl_state_t;

   // number of ways is fixed by the one-bit replacement state
   localparam int NWAYS = 2;

endpackage

// File: rtl/vipt_addr_map.sv
module vipt_addr_map #(
   parameter  int PA_W  = 12,
   parameter  int OFF_W = 3,
   parameter  int IDX_W = 2,
   parameter  int PG_W  = 4,
   localparam int VA_W  = (PG_W > OFF_W + IDX_W) ? PG_W : OFF_W + IDX_W,
   localparam int PPN_W = PA_W - PG_W,
   localparam int TAG_W = PA_W - OFF_W - IDX_W
)(
   input  logic [VA_W-1:0]  vaddr,
   input  logic [PPN_W-1:0] ppn,
   output logic [IDX_W-1:0] set_idx,
   output logic [TAG_W-1:0] tag,
   output logic [PA_W-1:0]  paddr
);

   // translated address: page number above the untranslated offset
   assign paddr = {ppn, vaddr[PG_W-1:0]};

   // set chosen from virtual bits, possibly reaching above the page offset
   assign set_idx = vaddr[OFF_W+IDX_W-1:OFF_W];

   // tag is the physical bits strictly above the index position
   assign tag = paddr[PA_W-1:OFF_W+IDX_W];

endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
   parameter  int NUM_SETS = 4,
   parameter  int TAG_W    = 7,
   parameter  int NWAYS    = 2,
   localparam int IDX_W    = $clog2(NUM_SETS),
   localparam int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic [NWAYS-1:0] hit_vec,
   output logic [NWAYS-1:0] vld_vec,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WAY_W-1:0] wr_way,
   input  logic [TAG_W-1:0] wr_tag
);

   for (genvar w = 0; w < NWAYS; w++) begin : g_way
      logic [NUM_SETS-1:0] vld_q;
      logic [TAG_W-1:0]    tag_q [NUM_SETS];
      logic                sel;

      assign sel = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk) begin
         if (rst) begin
            vld_q <= '0;
         end else if (sel) begin
            vld_q[wr_idx] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q[wr_idx] <= wr_tag;
         end
      end

      assign vld_vec[w] = vld_q[lk_idx];
      assign hit_vec[w] = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   end

   // R7
   hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit_vec));

endmodule

// File: rtl/vipt_lru_store.sv
module vipt_lru_store #(
   parameter  int NUM_SETS = 4,
   localparam int IDX_W    = $clog2(NUM_SETS)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [1:0]       vld_vec,
   output logic             victim,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_way
);

   logic [NUM_SETS-1:0] lru_q;

   // an empty way wins, lower way first; otherwise the stale way
   always_comb begin
      if (!vld_vec[0]) begin
         victim = 1'b0;
      end else if (!vld_vec[1]) begin
         victim = 1'b1;
      end else begin
         victim = lru_q[rd_idx];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lru_q <= '0;
      end else if (upd_en) begin
         lru_q[upd_idx] <= ~upd_way;
      end
   end

   // R6
   victim_free_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_vec != 2'b11) |-> !vld_vec[victim]);

endmodule

// File: rtl/vipt_tag_ctrl.sv
module vipt_tag_ctrl
   import vipt_pkg::*;
#(
   parameter  int PA_W       = 12,
   parameter  int LINE_BYTES = 8,
   parameter  int NUM_SETS   = 4,
   parameter  int PAGE_BYTES = 16,
   parameter  int MISS_LAT   = 16,
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int IDX_W      = $clog2(NUM_SETS),
   localparam int PG_W       = $clog2(PAGE_BYTES),
   localparam int VA_W       = (PG_W > OFF_W + IDX_W) ? PG_W : OFF_W + IDX_W,
   localparam int PPN_W      = PA_W - PG_W,
   localparam int TAG_W      = PA_W - OFF_W - IDX_W,
   localparam int CNT_W      = $clog2(MISS_LAT)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [PPN_W-1:0] req_ppn,
   output logic             req_ready,
   output logic             resp_valid,
   output logic             resp_hit,
   output logic             resp_way,
   output logic             fill_req,
   output logic [PA_W-1:0]  fill_paddr
);

   // ---------------- elaboration-time parameter checks ----------------
   if (LINE_BYTES < 2 || (1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (NUM_SETS < 2 || (1 << IDX_W) != NUM_SETS) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if ((1 << PG_W) != PAGE_BYTES || PG_W <= OFF_W) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two larger than a line");
   end
   if (PA_W <= OFF_W + IDX_W || PA_W <= PG_W) begin : g_bad_pa
      $error("PA_W must leave tag and page number bits");
   end
   if (MISS_LAT < 2) begin : g_bad_lat
      $error("MISS_LAT must be at least 2");
   end

   // ---------------- address split ----------------
   logic [IDX_W-1:0] lk_idx;
   logic [TAG_W-1:0] lk_tag;
   logic [PA_W-1:0]  lk_paddr;

   vipt_addr_map #(
      .PA_W  (PA_W),
      .OFF_W (OFF_W),
      .IDX_W (IDX_W),
      .PG_W  (PG_W)
   ) u_map (
      .vaddr   (req_vaddr),
      .ppn     (req_ppn),
      .set_idx (lk_idx),
      .tag     (lk_tag),
      .paddr   (lk_paddr)
   );

   // ---------------- control state ----------------
   ctl_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] pend_idx_q;
   logic [TAG_W-1:0] pend_tag_q;
   logic             pend_way_q;
   logic             resp_valid_q;
   logic             resp_hit_q;
   logic             resp_way_q;
   logic             fill_req_q;
   logic [PA_W-1:0]  fill_paddr_q;

   logic [NWAYS-1:0] hit_vec;
   logic [NWAYS-1:0] vld_vec;
   logic             hit_any;
   logic             hit_way;
   logic             victim;
   logic             accept;
   logic             fill_last;
   logic             lru_upd_en;
   logic [IDX_W-1:0] lru_upd_idx;
   logic             lru_upd_way;

   assign accept    = req_valid && (state_q == ST_IDLE);
   assign hit_any   = |hit_vec;
   assign hit_way   = hit_vec[1];
   assign fill_last = (state_q == ST_FILL) && (cnt_q == CNT_W'(MISS_LAT - 1));

   // ---------------- tag and valid arrays ----------------
   vipt_tag_store #(
      .NUM_SETS (NUM_SETS),
      .TAG_W    (TAG_W),
      .NWAYS    (NWAYS)
   ) u_tags (
      .clk     (clk),
      .rst     (rst),
      .lk_idx  (lk_idx),
      .lk_tag  (lk_tag),
      .hit_vec (hit_vec),
      .vld_vec (vld_vec),
      .wr_en   (fill_last),
      .wr_idx  (pend_idx_q),
      .wr_way  (pend_way_q),
      .wr_tag  (pend_tag_q)
   );

   // ---------------- replacement state ----------------
   assign lru_upd_en  = (accept && hit_any) || fill_last;
   assign lru_upd_idx = fill_last ? pend_idx_q : lk_idx;
   assign lru_upd_way = fill_last ? pend_way_q : hit_way;

   vipt_lru_store #(
      .NUM_SETS (NUM_SETS)
   ) u_lru (
      .clk     (clk),
      .rst     (rst),
      .rd_idx  (lk_idx),
      .vld_vec (vld_vec),
      .victim  (victim),
      .upd_en  (lru_upd_en),
      .upd_idx (lru_upd_idx),
      .upd_way (lru_upd_way)
   );

   // ---------------- sequencing ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q      <= ST_IDLE;
         cnt_q        <= '0;
         pend_idx_q   <= '0;
         pend_tag_q   <= '0;
         pend_way_q   <= 1'b0;
         resp_valid_q <= 1'b0;
         resp_hit_q   <= 1'b0;
         resp_way_q   <= 1'b0;
         fill_req_q   <= 1'b0;
         fill_paddr_q <= '0;
      end else begin
         resp_valid_q <= 1'b0;
         fill_req_q   <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (hit_any) begin
                     resp_valid_q <= 1'b1;
                     resp_hit_q   <= 1'b1;
                     resp_way_q   <= hit_way;
                  end else begin
                     state_q      <= ST_FILL;
                     cnt_q        <= CNT_W'(1);
                     fill_req_q   <= 1'b1;
                     fill_paddr_q <= lk_paddr;
                     pend_idx_q   <= lk_idx;
                     pend_tag_q   <= lk_tag;
                     pend_way_q   <= victim;
                  end
               end
            end
            ST_FILL: begin
               if (fill_last) begin
                  state_q      <= ST_IDLE;
                  cnt_q        <= '0;
                  resp_valid_q <= 1'b1;
                  resp_hit_q   <= 1'b0;
                  resp_way_q   <= pend_way_q;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign resp_valid = resp_valid_q;
   assign resp_hit   = resp_hit_q;
   assign resp_way   = resp_way_q;
   assign fill_req   = fill_req_q;
   assign fill_paddr = fill_paddr_q;

   // ---------------- properties ----------------
   // R3
   hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
      (resp_valid_q && resp_hit_q) |-> $past(req_valid && req_ready));

   // R4
   miss_resp_chk: assert property (@(posedge clk) disable iff (rst)
      (resp_valid_q && !resp_hit_q) |-> $past(!req_ready));

   // R5
   fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      fill_req_q |=> !fill_req_q);

   // R5
   fill_busy_chk: assert property (@(posedge clk) disable iff (rst)
      fill_req_q |-> !req_ready);

endmodule

// File: tb/sim_vipt_tag_ctrl.sv
`timescale 1ns/1ps
module sim_vipt_tag_ctrl;

   localparam int PA_W     = 12;
   localparam int MISS_LAT = 16;
   localparam int VA_W     = 5;
   localparam int PPN_W    = 8;

   logic             clk = 1'b0;
   logic             rst;
   logic             req_valid;
   logic [VA_W-1:0]  req_vaddr;
   logic [PPN_W-1:0] req_ppn;
   logic             req_ready;
   logic             resp_valid;
   logic             resp_hit;
   logic             resp_way;
   logic             fill_req;
   logic [PA_W-1:0]  fill_paddr;

   always #10 clk = ~clk;

   vipt_tag_ctrl #(.PA_W(PA_W), .MISS_LAT(MISS_LAT)) u0 (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (req_valid),
      .req_vaddr  (req_vaddr),
      .req_ppn    (req_ppn),
      .req_ready  (req_ready),
      .resp_valid (resp_valid),
      .resp_hit   (resp_hit),
      .resp_way   (resp_way),
      .fill_req   (fill_req),
      .fill_paddr (fill_paddr)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // ---------------- behavioural reference model ----------------
   int m_vld [4][2];
   int m_tag [4][2];
   int m_lru [4];
   int m_busy, p_set, p_way, p_tag;
   int ms, mt, mh;
   bit m_live;
   int e_rv, e_hit, e_way, e_fill, e_fpa;

   always @(posedge clk) begin
      e_rv   = 0;
      e_fill = 0;
      if (rst) begin
         for (int s = 0; s < 4; s++) begin
            m_lru[s] = 0;
            for (int w = 0; w < 2; w++) m_vld[s][w] = 0;
         end
         m_busy = 0;
         m_live = 0;
      end else begin
         m_live = 1;
         if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) begin
               m_vld[p_set][p_way] = 1;
               m_tag[p_set][p_way] = p_tag;
               m_lru[p_set]        = 1 - p_way;
               e_rv  = 1;
               e_hit = 0;
               e_way = p_way;
            end
         end else if (req_valid) begin
            ms = (int'(req_vaddr) >> 3) & 3;
            mt = int'(req_ppn) >> 1;
            mh = -1;
            for (int w = 0; w < 2; w++)
               if (m_vld[ms][w] != 0 && m_tag[ms][w] == mt) mh = w;
            if (mh >= 0) begin
               e_rv  = 1;
               e_hit = 1;
               e_way = mh;
               m_lru[ms] = 1 - mh;
            end else begin
               p_set = ms;
               p_tag = mt;
               if (m_vld[ms][0] == 0)      p_way = 0;
               else if (m_vld[ms][1] == 0) p_way = 1;
               else                        p_way = m_lru[ms];
               m_busy = MISS_LAT - 1;
               e_fill = 1;
               e_fpa  = int'(req_ppn) * 16 + (int'(req_vaddr) & 15);
            end
         end
      end
   end

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (m_live) begin
         chk("R4 req_ready", int'(req_ready), (m_busy == 0) ? 1 : 0);
         chk("R3 resp_valid", int'(resp_valid), e_rv);
         if (e_rv != 0 && resp_valid) begin
            chk("R3 resp_hit", int'(resp_hit), e_hit);
            chk("R7 resp_way", int'(resp_way), e_way);
         end
         chk("R5 fill_req", int'(fill_req), e_fill);
         if (e_fill != 0 && fill_req) chk("R2 fill_paddr", int'(fill_paddr), e_fpa);
      end
   end

   // ---------------- directed access with hand-computed expectations ----------------
   task automatic access(input logic [4:0] va, input logic [7:0] ppn,
                         input int exp_hit, input int exp_way, input string rq);
      int cyc;
      int seen_fill;
      int fpa;
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      req_ppn   = ppn;
      while (!req_ready) @(negedge clk);
      cyc       = 0;
      seen_fill = 0;
      fpa       = 0;
      do begin
         @(negedge clk);
         req_valid = 1'b0;
         cyc++;
         if (fill_req) begin
            seen_fill = 1;
            fpa       = int'(fill_paddr);
         end
      end while (!resp_valid && cyc < 100);
      chk({rq, " hit flag"}, int'(resp_hit), exp_hit);
      chk({rq, " way"}, int'(resp_way), exp_way);
      chk(exp_hit != 0 ? "R3 hit latency" : "R4 miss latency", cyc,
          exp_hit != 0 ? 1 : MISS_LAT);
      if (exp_hit == 0) begin
         chk("R5 fill pulse seen", seen_fill, 1);
         chk("R5 fill address", fpa, int'({ppn, va[3:0]}));
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual no completion expected completion");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      int pulses;
      rst       = 1'b1;
      req_valid = 1'b0;
      req_vaddr = '0;
      req_ppn   = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 idle state after reset
      chk("R1 ready after reset", int'(req_ready), 1);
      chk("R1 no response after reset", int'(resp_valid), 0);
      chk("R1 no fill after reset", int'(fill_req), 0);

      access(5'h14, 8'h03, 0, 0, "R1");   // set 2, tag 1: cold miss
      access(5'h18, 8'h03, 0, 0, "R6");   // set 3: empty way 0
      access(5'h10, 8'h03, 1, 0, "R3");   // set 2 hit
      access(5'h14, 8'h02, 1, 0, "R2");   // ppn bit 0 outside the tag
      access(5'h14, 8'h05, 0, 1, "R6");   // set 2 tag 2: empty way 1
      access(5'h14, 8'h07, 0, 0, "R7");   // both valid, way 0 stale
      access(5'h14, 8'h05, 1, 1, "R7");   // way 1 survived
      access(5'h14, 8'h03, 0, 0, "R7");   // tag 1 was evicted, way 0 stale
      access(5'h10, 8'h07, 0, 1, "R7");   // tag 3 evicted, way 1 stale

      // R8: a request raised while busy must be dropped
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = 5'h08;
      req_ppn   = 8'h20;
      @(negedge clk);
      req_vaddr = 5'h00;
      req_ppn   = 8'h10;
      chk("R8 busy during fill", int'(req_ready), 0);
      @(negedge clk);
      req_valid = 1'b0;
      pulses = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (resp_valid) pulses++;
      end
      chk("R8 single response", pulses, 1);
      access(5'h00, 8'h10, 0, 0, "R8");   // would hit had the busy request been taken

      // back-to-back traffic with valid held, checked by the model
      for (int i = 0; i < 48; i++) begin
         @(negedge clk);
         req_valid = (i % 5) != 4;
         req_vaddr = 5'(i * 3);
         req_ppn   = 8'(i % 6);
      end
      @(negedge clk);
      req_valid = 1'b0;
      repeat (40) @(negedge clk);

      // R1: a second reset forgets installed lines
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 ready after second reset", int'(req_ready), 1);
      access(5'h10, 8'h03, 0, 0, "R1");
      access(5'h10, 8'h03, 1, 0, "R3");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule